// File: doc/BRIEF.md
# Multiplexed bus strobe port

This block manages eight bidirectional pads. Each pad works on its own either as a general-purpose I/O bit or as an external-bus control output. In control mode, pad n carries the chip select of memory block n. On the four blocks that can hold DRAM (1, 3, 4 and 6), the same pad also carries that block's row address strobe. A separate pair of pads carries the I/O read and I/O write strobes. Software sets three registers through a simple write port: per-bit mode, per-bit direction and output data. Bus-cycle status comes from a bus controller: whether a cycle is active, its target block, its kind, its direction, DRAM page mode, flyby transfer, I/O-enable and bus hold.

All strobes are active low. Every pad value and every output enable is registered, so a change on the inputs appears on the pads one clock later. A register write therefore reaches the pads two clocks after it is issued. In page mode, a row strobe that a DRAM access has asserted stays low after the cycle ends. It is released by a DRAM access to another block, by a refresh, by bus hold or by reset.

Top module: `bus_strobe_port`

## Requirements
- R1: While `rst` is high, all pad enables and `io_oe` are 0, `pad_o` is 0 and both I/O strobes are 1. After reset every bit is in port mode, is an input and holds data 0.
- R2: Register writes with `reg_we`=1 use `reg_sel`: 0 selects mode (1 = control), 1 selects direction (1 = output), 2 selects data. A port-mode pad n drives `pad_oe[n]` from the direction bit and `pad_o[n]` from the data bit.
- R3: `port_in` shows `pad_i` one clock later.
- R4: A control-mode pad n is low while a cycle of kind SRAM (0), ROM (1), external I/O (2) or DRAM (3) targets block n. It is high when idle. Mixed-mode bit groups work independently.
- R5: Pads 1, 3, 4 and 6 are also low during a DRAM (3) or refresh (4) cycle to their block. A refresh to any other block asserts nothing.
- R6: If `page_en` is 0 during a DRAM cycle, that block's row strobe rises once the cycle ends. If `page_en` is 1, it stays low after the cycle.
- R7: A held row strobe is released by a DRAM cycle to another block, by any refresh, by bus hold or by reset. At most one strobe is held at a time.
- R8: While `bus_hold` is high, control-mode pads and `io_oe` are not enabled. Otherwise they are enabled.
- R9: Without I/O-enable, I/O strobes assert for SRAM cycles and for external I/O cycles with `flyby`=1. `cyc_wr`=1 selects `iowr_n` and `cyc_wr`=0 selects `iord_n`. The two are never low together. ROM cycles and non-flyby external I/O cycles give no strobe.
- R10: With `io_en`=1, ROM and external I/O cycles also drive the I/O strobes.
- R11: Bus hold has no effect on port-mode pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (also bus reset status) |
| bus_hold | input | 1 | Bus hold period in progress |
| cyc_act | input | 1 | Bus cycle active |
| cyc_blk | input | 3 | Target memory block |
| cyc_type | input | 3 | Cycle kind: 0 SRAM, 1 ROM, 2 ext I/O, 3 DRAM, 4 refresh |
| cyc_wr | input | 1 | Cycle is a write |
| page_en | input | 1 | DRAM page mode enabled |
| flyby | input | 1 | Cycle belongs to a flyby DMA transfer |
| io_en | input | 1 | I/O strobes also on ordinary cycles |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 direction, 2 data |
| reg_wdata | input | 8 | Register write data |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| port_in | output | 8 | Sampled pad input levels |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| io_oe | output | 1 | Output enable of the I/O strobe pads |

## Verification
The assertions check several rules on every cycle. Port-mode enables follow the direction register. Hold removes the enables from control pads and strobe pads. The two I/O strobes are never low together. At most one row strobe is held, and hold clears it. A DRAM cycle without page mode leaves nothing held. Idle registers stay unchanged. Only the bench scenarios show the pad values that result for each cycle kind and block, the merged chip-select and row-strobe pads, and the order of release events in page mode.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [2:0] {
    CY_SRAM  = 3'd0,
    CY_ROM   = 3'd1,
    CY_EXTIO = 3'd2,
    CY_DRAM  = 3'd3,
    CY_REFR  = 3'd4
  } cyc_kind_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/bsp_port_regs.sv
module bsp_port_regs
  import bsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_we,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q,
  output logic [W-1:0] port_in
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      dir_q   <= '0;
      data_q  <= '0;
      port_in <= '0;
    end else begin
      port_in <= pad_i;
      if (reg_we) begin
        case (reg_sel)
          SEL_MODE: mode_q <= reg_wdata;
          SEL_DIR:  dir_q  <= reg_wdata;
          SEL_DATA: data_q <= reg_wdata;
          default:  ;
        endcase
      end
    end
  end

  // R2: registers change only on a write
  p_regs_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> ($stable(mode_q) && $stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/bsp_strobe_ctl.sv
module bsp_strobe_ctl
  import bsp_pkg::*;
#(
  parameter int            NBLK     = 8,
  parameter logic [NBLK-1:0] RAS_MASK = 8'b0101_1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_hold,
  input  logic              cyc_act,
  input  logic [$clog2(NBLK)-1:0] cyc_blk,
  input  logic [2:0]        cyc_type,
  input  logic              cyc_wr,
  input  logic              page_en,
  input  logic              flyby,
  input  logic              io_en,
  output logic [NBLK-1:0]   blk_act,
  output logic              io_rd,
  output logic              io_wr
);
  localparam int BW = $clog2(NBLK);

  logic [NBLK-1:0] ras_hold;
  logic [NBLK-1:0] blk_onehot;
  logic            io_cyc;

  assign blk_onehot = NBLK'(1) << cyc_blk;

  for (genvar n = 0; n < NBLK; n++) begin : g_blk
    logic sel;
    assign sel = cyc_act && (cyc_blk == BW'(n));
    // chip select for any access kind, row strobe for refresh, held strobe
    assign blk_act[n] = (sel && (cyc_type <= CY_DRAM))
                      || (RAS_MASK[n] && sel && (cyc_type == CY_REFR))
                      || ras_hold[n];
  end

  always_ff @(posedge clk) begin
    if (rst || bus_hold)
      ras_hold <= '0;
    else if (cyc_act && cyc_type == CY_REFR)
      ras_hold <= '0;
    else if (cyc_act && cyc_type == CY_DRAM)
      ras_hold <= page_en ? (blk_onehot & RAS_MASK) : '0;
  end

  assign io_cyc = cyc_act && ((cyc_type == CY_SRAM)
                || (flyby && cyc_type == CY_EXTIO)
                || (io_en && (cyc_type == CY_ROM || cyc_type == CY_EXTIO)));
  assign io_rd  = io_cyc && !cyc_wr;
  assign io_wr  = io_cyc && cyc_wr;

  // R7: never more than one held row strobe
  p_held_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ras_hold));
  // R7: bus hold releases any held strobe
  p_hold_release_r7: assert property (@(posedge clk) disable iff (rst)
    bus_hold |=> (ras_hold == '0));
  // R6: a DRAM cycle without page mode leaves nothing held
  p_page_off_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && cyc_type == CY_DRAM && !page_en && !bus_hold) |=> (ras_hold == '0));
endmodule

// File: rtl/bsp_pad_mux.sv
module bsp_pad_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_hold,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic [W-1:0] blk_act,
  input  logic         io_rd,
  input  logic         io_wr,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe,
  output logic         iord_n,
  output logic         iowr_n,
  output logic         io_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= '0;
      pad_oe <= '0;
      iord_n <= 1'b1;
      iowr_n <= 1'b1;
      io_oe  <= 1'b0;
    end else begin
      for (int n = 0; n < W; n++) begin
        pad_o[n]  <= mode[n] ? ~blk_act[n] : data[n];
        pad_oe[n] <= mode[n] ? ~bus_hold   : dir[n];
      end
      iord_n <= ~io_rd;
      iowr_n <= ~io_wr;
      io_oe  <= ~bus_hold;
    end
  end

  // R2: port-mode enables follow the direction register
  p_port_dir_r2: assert property (@(posedge clk) disable iff (rst)
    ((~$past(mode)) & (pad_oe ^ $past(dir))) == '0);
  // R8: hold turns off control pads and strobe pads
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bus_hold |=> (((pad_oe & $past(mode)) == '0) && !io_oe));
  // R9: read and write strobes exclusive
  p_io_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!iord_n && !iowr_n));
endmodule

// File: rtl/bus_strobe_port.sv
module bus_strobe_port
  import bsp_pkg::*;
#(
  parameter int              NPIN     = 8,
  parameter logic [NPIN-1:0] RAS_MASK = 8'b0101_1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_hold,
  input  logic              cyc_act,
  input  logic [$clog2(NPIN)-1:0] cyc_blk,
  input  logic [2:0]        cyc_type,
  input  logic              cyc_wr,
  input  logic              page_en,
  input  logic              flyby,
  input  logic              io_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [NPIN-1:0]   reg_wdata,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   port_in,
  output logic              iord_n,
  output logic              iowr_n,
  output logic              io_oe
);
  logic [NPIN-1:0] mode_q, dir_q, data_q, blk_act;
  logic            io_rd, io_wr;

  bsp_port_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pad_i(pad_i), .mode_q(mode_q),
    .dir_q(dir_q), .data_q(data_q), .port_in(port_in)
  );

  bsp_strobe_ctl #(.NBLK(NPIN), .RAS_MASK(RAS_MASK)) u_ctl (
    .clk(clk), .rst(rst), .bus_hold(bus_hold), .cyc_act(cyc_act),
    .cyc_blk(cyc_blk), .cyc_type(cyc_type), .cyc_wr(cyc_wr),
    .page_en(page_en), .flyby(flyby), .io_en(io_en),
    .blk_act(blk_act), .io_rd(io_rd), .io_wr(io_wr)
  );

  bsp_pad_mux #(.W(NPIN)) u_mux (
    .clk(clk), .rst(rst), .bus_hold(bus_hold), .mode(mode_q),
    .dir(dir_q), .data(data_q), .blk_act(blk_act), .io_rd(io_rd),
    .io_wr(io_wr), .pad_o(pad_o), .pad_oe(pad_oe), .iord_n(iord_n),
    .iowr_n(iowr_n), .io_oe(io_oe)
  );
endmodule

// File: tb/bus_strobe_port_bench.sv
module bus_strobe_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_hold = 0, cyc_act = 0, cyc_wr = 0, page_en = 0, flyby = 0, io_en = 0;
  logic [2:0] cyc_blk = 0, cyc_type = 0;
  logic       reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, pad_i = 0;
  logic [7:0] pad_o, pad_oe, port_in;
  logic       iord_n, iowr_n, io_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_strobe_port u_bus_strobe_port (
    .clk(clk), .rst(rst), .bus_hold(bus_hold), .cyc_act(cyc_act),
    .cyc_blk(cyc_blk), .cyc_type(cyc_type), .cyc_wr(cyc_wr),
    .page_en(page_en), .flyby(flyby), .io_en(io_en), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .port_in(port_in),
    .iord_n(iord_n), .iowr_n(iowr_n), .io_oe(io_oe)
  );

  typedef struct packed {
    logic [7:0] mode, dir, data;
    logic       act;
    logic [2:0] blk, typ;
    logic       wr, fly, ioen, hold;
    logic [7:0] eo, eoe;
    logic       erd, ewr, eiooe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'h00,8'hF0,8'hA5, 1'b0,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b0, 8'hA5,8'hF0, 1'b1,1'b1,1'b1, 4'd2},  // R2
    '{8'hFF,8'h00,8'h00, 1'b1,3'd2,3'd0, 1'b0,1'b0,1'b0,1'b0, 8'hFB,8'hFF, 1'b0,1'b1,1'b1, 4'd4},  // R4 SRAM read
    '{8'hFF,8'h00,8'h00, 1'b1,3'd6,3'd3, 1'b1,1'b0,1'b0,1'b0, 8'hBF,8'hFF, 1'b1,1'b1,1'b1, 4'd5},  // R5 DRAM
    '{8'hFF,8'h00,8'h00, 1'b1,3'd3,3'd4, 1'b0,1'b0,1'b0,1'b0, 8'hF7,8'hFF, 1'b1,1'b1,1'b1, 4'd5},  // R5 refresh
    '{8'hFF,8'h00,8'h00, 1'b1,3'd2,3'd4, 1'b0,1'b0,1'b0,1'b0, 8'hFF,8'hFF, 1'b1,1'b1,1'b1, 4'd5},  // R5 refresh non-DRAM block
    '{8'h0F,8'hF0,8'h3C, 1'b1,3'd0,3'd0, 1'b1,1'b0,1'b0,1'b0, 8'h3E,8'hFF, 1'b1,1'b0,1'b1, 4'd4},  // R4 mixed
    '{8'hFF,8'h00,8'h00, 1'b1,3'd5,3'd1, 1'b0,1'b0,1'b0,1'b0, 8'hDF,8'hFF, 1'b1,1'b1,1'b1, 4'd9},  // R9 ROM no strobe
    '{8'hFF,8'h00,8'h00, 1'b1,3'd5,3'd1, 1'b0,1'b0,1'b1,1'b0, 8'hDF,8'hFF, 1'b0,1'b1,1'b1, 4'd10}, // R10 ROM
    '{8'hFF,8'h00,8'h00, 1'b1,3'd7,3'd2, 1'b1,1'b0,1'b0,1'b0, 8'h7F,8'hFF, 1'b1,1'b1,1'b1, 4'd9},  // R9 ext I/O no flyby
    '{8'hFF,8'h00,8'h00, 1'b1,3'd7,3'd2, 1'b1,1'b1,1'b0,1'b0, 8'h7F,8'hFF, 1'b1,1'b0,1'b1, 4'd9},  // R9 flyby write
    '{8'hFF,8'h00,8'h00, 1'b1,3'd7,3'd2, 1'b0,1'b0,1'b1,1'b0, 8'h7F,8'hFF, 1'b0,1'b1,1'b1, 4'd10}, // R10 ext I/O read
    '{8'hFF,8'h00,8'h00, 1'b0,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b1, 8'hFF,8'h00, 1'b1,1'b1,1'b0, 4'd8},  // R8 hold
    '{8'h00,8'hFF,8'h5A, 1'b0,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b1, 8'h5A,8'hFF, 1'b1,1'b1,1'b0, 4'd11}  // R11
  };

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] val);
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic bus(input logic act, input logic [2:0] blk, input logic [2:0] typ,
                     input logic pg, input logic hd);
    cyc_act = act; cyc_blk = blk; cyc_type = typ; page_en = pg; bus_hold = hd;
    cyc_wr = 0; flyby = 0; io_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", "oe in reset", pad_oe, 8'h00);
    chk("R1", "io_oe in reset", {7'd0, io_oe}, 8'h00);
    chk("R1", "strobes in reset", {6'd0, iord_n, iowr_n}, 8'h03);
    rst = 0;
    settle();
    chk("R1", "pad_o after reset", pad_o, 8'h00);
    chk("R1", "oe after reset", pad_oe, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VEC[i].req);
      wreg(2'd0, VEC[i].mode);
      wreg(2'd1, VEC[i].dir);
      wreg(2'd2, VEC[i].data);
      cyc_act = VEC[i].act; cyc_blk = VEC[i].blk; cyc_type = VEC[i].typ;
      cyc_wr = VEC[i].wr; flyby = VEC[i].fly; io_en = VEC[i].ioen;
      bus_hold = VEC[i].hold; page_en = 0;
      settle();
      chk(r, $sformatf("v%0d pad_o", i), pad_o, VEC[i].eo);
      chk(r, $sformatf("v%0d pad_oe", i), pad_oe, VEC[i].eoe);
      chk(r, $sformatf("v%0d strobes", i), {5'd0, iord_n, iowr_n, io_oe},
          {5'd0, VEC[i].erd, VEC[i].ewr, VEC[i].eiooe});
      bus(0, 0, 0, 0, 0);
      settle();
    end

    // R3: input sampling
    pad_i = 8'h96;
    settle();
    chk("R3", "port_in", port_in, 8'h96);

    wreg(2'd0, 8'hFF);
    // R6: page mode keeps strobe
    bus(1, 4, 3, 1, 0); settle(); chk("R5", "dram blk4", pad_o, 8'hEF);
    bus(0, 0, 0, 0, 0); settle(); chk("R6", "held after cycle", pad_o, 8'hEF);
    // R7: DRAM access to another block moves the held strobe
    bus(1, 1, 3, 1, 0); settle(); chk("R7", "other block", pad_o, 8'hFD);
    bus(0, 0, 0, 0, 0); settle(); chk("R7", "blk1 held", pad_o, 8'hFD);
    // R7: refresh releases
    bus(1, 3, 4, 0, 0); settle(); chk("R7", "refresh", pad_o, 8'hF7);
    bus(0, 0, 0, 0, 0); settle(); chk("R7", "after refresh", pad_o, 8'hFF);
    // R6: page off releases at cycle end
    bus(1, 4, 3, 0, 0); settle(); chk("R6", "dram nopage", pad_o, 8'hEF);
    bus(0, 0, 0, 0, 0); settle(); chk("R6", "released", pad_o, 8'hFF);
    // R7: hold releases
    bus(1, 6, 3, 1, 0); settle();
    bus(0, 0, 0, 0, 0); settle(); chk("R6", "blk6 held", pad_o, 8'hBF);
    bus(0, 0, 0, 0, 1); settle(); chk("R8", "hold oe", pad_oe, 8'h00);
    bus(0, 0, 0, 0, 0); settle(); chk("R7", "after hold", pad_o, 8'hFF);
    chk("R8", "oe back", pad_oe, 8'hFF);
    // R7: reset releases
    bus(1, 6, 3, 1, 0); settle();
    bus(0, 0, 0, 0, 0); settle(); chk("R6", "blk6 held again", pad_o, 8'hBF);
    rst = 1; settle(); chk("R1", "oe in reset 2", pad_oe, 8'h00);
    rst = 0; settle(); chk("R1", "mode reset", pad_oe, 8'h00);
    wreg(2'd0, 8'hFF); settle(); chk("R7", "after reset", pad_o, 8'hFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule